// File: doc/BRIEF.md
# Path Status and User-Channel Overhead Inserter

This block forms two transmit path-overhead bytes for a SONET/SDH framer: the path status byte (G1) and the path user-channel byte (F2). It serves up to three STS-1 paths at once, or a single STM-1 path. For each path it takes a B3 block-error count and a set of path defect flags from two places: the local receive side and a protection board. It also takes per-path register controls. Separate G1 and F2 slot strobes for each path tell the block when the byte is due, and the registered byte is presented on the cycle after the strobe.

The G1 byte carries the remote error indication (REI) count in its upper nibble and the remote defect indication (RDI) code in the three bits below it. The RDI code is encoded in either non-enhanced or enhanced mode. A global select switches both fields over to the protection-board inputs. Each path has an inhibit bit that stops automatic REI. While the bit is set, the path's REI comes only from a global software error-injection pulse. F2 is chosen from three sources in a fixed priority: a register byte, a path-overhead access (POAC) byte, and an all-zeros or all-ones default.

Top module: `path_oh_inserter`

## Requirements
- R1: A G1 byte is laid out as REI in bits [7:4], RDI code in bits [3:1], and bit 0 always 0.
- R2: With inhibit clear, REI equals the selected 4-bit error count of the path (path p uses count bits [4p+3:4p]), and any count above 8 is sent as 8.
- R3: Each path has 5 defect bits at [5p+4:5p], ordered as bit0 AIS-P, bit1 LOP-P, bit2 TIM-P, bit3 UNEQ-P, bit4 PLM-P. In non-enhanced mode the RDI code is 100 when AIS-P or LOP-P is set, and 000 otherwise. TIM-P, UNEQ-P and PLM-P have no effect in this mode.
- R4: In enhanced mode the RDI code is 101 for AIS-P or LOP-P, else 110 for TIM-P or UNEQ-P, else 010 for PLM-P, else 001.
- R5: When the protection select is 1, both REI and RDI are built from the protection-board count and defects. When it is 0, both come from the local receive count and defects.
- R6: With the path's inhibit set, the REI field is 0000 whatever the count, except on a byte that carries an injected error.
- R7: An error-injection pulse seen while the path is inhibited makes the next G1 byte of that path carry REI 0001 exactly once. This holds even when several pulses arrive before that byte. A pulse in the same cycle as the path's G1 strobe applies to that byte and leaves nothing pending.
- R8: In STM-1 mode every path takes its inhibit from the path 0 inhibit bit, and the other inhibit bits are ignored.
- R9: F2 is the per-path register byte if its enable is set. Otherwise it is the POAC byte if the POAC enable is set. Otherwise it is 0x00 when the default bit is 0, and 0xFF when the default bit is 1.
- R10: Reset clears all outputs to 0. Each G1 or F2 output changes only in the cycle after its own path's slot strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stm1_mode | input | 1 | 1 = single STM-1 path, inhibit taken from path 0 |
| enh_rdi | input | 1 | 1 = enhanced RDI encoding |
| prot_sel | input | 1 | 1 = REI/RDI from protection board |
| loc_err_cnt | input | 4*NUM_PATHS | Local B3 errored-block counts |
| loc_defects | input | 5*NUM_PATHS | Local path defect flags |
| prot_err_cnt | input | 4*NUM_PATHS | Protection-board error counts |
| prot_defects | input | 5*NUM_PATHS | Protection-board defect flags |
| rei_inh | input | NUM_PATHS | Per-path automatic REI inhibit |
| err_inject | input | 1 | Global software error-injection pulse |
| f2_reg_en | input | NUM_PATHS | Per-path F2 register-source enable |
| f2_reg_val | input | 8*NUM_PATHS | Per-path F2 register byte |
| poac_f2_en | input | NUM_PATHS | Per-path POAC F2 enable |
| poac_f2_val | input | 8*NUM_PATHS | Per-path POAC F2 byte |
| oh_default | input | 1 | Fill value for F2 when no source is enabled |
| g1_slot | input | NUM_PATHS | Per-path G1 byte-slot strobe |
| f2_slot | input | NUM_PATHS | Per-path F2 byte-slot strobe |
| g1_out | output | 8*NUM_PATHS | Registered G1 bytes |
| f2_out | output | 8*NUM_PATHS | Registered F2 bytes |

## Verification
An error-injection pulse can land in the same cycle as the G1 strobe of an inhibited path. In that cycle the pulse must be consumed immediately and must not also stay pending. The bench drives the pulse and the strobe on one edge and expects REI 0001 on that byte. It then expects REI 0000 on the next byte. A second case queues two pulses between slots and expects a single 0001, followed by 0000.

// File: rtl/oh_ins_pkg.sv
package oh_ins_pkg;

  localparam int DEF_W = 5;
  localparam int REI_W = 4;
  localparam int RDI_W = 3;

  // bit0 = ais ... bit4 = plm
  typedef struct packed {
    logic plm;
    logic uneq;
    logic tim;
    logic lop;
    logic ais;
  } path_def_t;

  localparam logic [RDI_W-1:0] RDI_NE_CLEAR = 3'b000;
  localparam logic [RDI_W-1:0] RDI_NE_SRV   = 3'b100;
  localparam logic [RDI_W-1:0] RDI_EN_CLEAR = 3'b001;
  localparam logic [RDI_W-1:0] RDI_EN_PAY   = 3'b010;
  localparam logic [RDI_W-1:0] RDI_EN_SRV   = 3'b101;
  localparam logic [RDI_W-1:0] RDI_EN_CONN  = 3'b110;

endpackage

// File: rtl/rdi_encoder.sv
module rdi_encoder
  import oh_ins_pkg::*;
(
  input  path_def_t              defs,
  input  logic                   enh,
  output logic [RDI_W-1:0]       code
);

  logic srv_hit;
  logic conn_hit;

  always_comb begin
    srv_hit  = defs.ais | defs.lop;
    conn_hit = defs.tim | defs.uneq;
    if (enh) begin
      if (srv_hit)        code = RDI_EN_SRV;
      else if (conn_hit)  code = RDI_EN_CONN;
      else if (defs.plm)  code = RDI_EN_PAY;
      else                code = RDI_EN_CLEAR;
    end else begin
      code = srv_hit ? RDI_NE_SRV : RDI_NE_CLEAR;
    end
  end

endmodule

// File: rtl/rei_unit.sv
module rei_unit
  import oh_ins_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int MAX_REI = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              inh,
  input  logic              err_pulse,
  input  logic              slot,
  output logic [REI_W-1:0]  rei
);

  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MAX_REI);

  logic              pend_q;
  logic [CNT_W-1:0]  capped;

  always_comb begin
    capped = (cnt > CNT_CAP) ? CNT_CAP : cnt;
    if (inh)
      rei = (pend_q | err_pulse) ? REI_W'(1) : '0;
    else
      rei = REI_W'(capped);
  end

  // one queued injection per path, consumed by the next G1 slot
  always_ff @(posedge clk) begin
    if (rst)
      pend_q <= 1'b0;
    else if (slot || !inh)
      pend_q <= 1'b0;
    else if (err_pulse)
      pend_q <= 1'b1;
  end

endmodule

// File: rtl/g1_path_unit.sv
module g1_path_unit
  import oh_ins_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int MAX_REI = 8,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enh,
  input  logic              prot_sel,
  input  logic [CNT_W-1:0]  loc_cnt,
  input  path_def_t         loc_def,
  input  logic [CNT_W-1:0]  prot_cnt,
  input  path_def_t         prot_def,
  input  logic              inh,
  input  logic              err_pulse,
  input  logic              slot,
  output logic [BYTE_W-1:0] g1_q
);

  logic [CNT_W-1:0] cnt_sel;
  path_def_t        def_sel;
  logic [REI_W-1:0] rei_val;
  logic [RDI_W-1:0] rdi_val;

  always_comb begin
    cnt_sel = prot_sel ? prot_cnt : loc_cnt;
    def_sel = prot_sel ? prot_def : loc_def;
  end

  rei_unit #(.CNT_W(CNT_W), .MAX_REI(MAX_REI)) u_rei (
    .clk       (clk),
    .rst       (rst),
    .cnt       (cnt_sel),
    .inh       (inh),
    .err_pulse (err_pulse),
    .slot      (slot),
    .rei       (rei_val)
  );

  rdi_encoder u_rdi (
    .defs (def_sel),
    .enh  (enh),
    .code (rdi_val)
  );

  always_ff @(posedge clk) begin
    if (rst)
      g1_q <= '0;
    else if (slot)
      g1_q <= BYTE_W'({rei_val, rdi_val, 1'b0});
  end

endmodule

// File: rtl/f2_path_unit.sv
module f2_path_unit #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_en,
  input  logic [BYTE_W-1:0] reg_val,
  input  logic              poac_en,
  input  logic [BYTE_W-1:0] poac_val,
  input  logic              fill,
  input  logic              slot,
  output logic [BYTE_W-1:0] f2_q
);

  logic [BYTE_W-1:0] f2_d;

  always_comb begin
    if (reg_en)       f2_d = reg_val;
    else if (poac_en) f2_d = poac_val;
    else              f2_d = {BYTE_W{fill}};
  end

  always_ff @(posedge clk) begin
    if (rst)
      f2_q <= '0;
    else if (slot)
      f2_q <= f2_d;
  end

endmodule

// File: rtl/path_oh_inserter.sv
module path_oh_inserter
  import oh_ins_pkg::*;
#(
  parameter int NUM_PATHS = 3,
  parameter int CNT_W     = 4,
  parameter int MAX_REI   = 8,
  parameter int BYTE_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          stm1_mode,
  input  logic                          enh_rdi,
  input  logic                          prot_sel,
  input  logic [NUM_PATHS*CNT_W-1:0]    loc_err_cnt,
  input  logic [NUM_PATHS*DEF_W-1:0]    loc_defects,
  input  logic [NUM_PATHS*CNT_W-1:0]    prot_err_cnt,
  input  logic [NUM_PATHS*DEF_W-1:0]    prot_defects,
  input  logic [NUM_PATHS-1:0]          rei_inh,
  input  logic                          err_inject,
  input  logic [NUM_PATHS-1:0]          f2_reg_en,
  input  logic [NUM_PATHS*BYTE_W-1:0]   f2_reg_val,
  input  logic [NUM_PATHS-1:0]          poac_f2_en,
  input  logic [NUM_PATHS*BYTE_W-1:0]   poac_f2_val,
  input  logic                          oh_default,
  input  logic [NUM_PATHS-1:0]          g1_slot,
  input  logic [NUM_PATHS-1:0]          f2_slot,
  output logic [NUM_PATHS*BYTE_W-1:0]   g1_out,
  output logic [NUM_PATHS*BYTE_W-1:0]   f2_out
);

  logic [NUM_PATHS-1:0] inh_eff;

  always_comb begin
    for (int p = 0; p < NUM_PATHS; p++)
      inh_eff[p] = stm1_mode ? rei_inh[0] : rei_inh[p];
  end

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    g1_path_unit #(
      .CNT_W   (CNT_W),
      .MAX_REI (MAX_REI),
      .BYTE_W  (BYTE_W)
    ) u_g1 (
      .clk       (clk),
      .rst       (rst),
      .enh       (enh_rdi),
      .prot_sel  (prot_sel),
      .loc_cnt   (loc_err_cnt[p*CNT_W +: CNT_W]),
      .loc_def   (path_def_t'(loc_defects[p*DEF_W +: DEF_W])),
      .prot_cnt  (prot_err_cnt[p*CNT_W +: CNT_W]),
      .prot_def  (path_def_t'(prot_defects[p*DEF_W +: DEF_W])),
      .inh       (inh_eff[p]),
      .err_pulse (err_inject),
      .slot      (g1_slot[p]),
      .g1_q      (g1_out[p*BYTE_W +: BYTE_W])
    );

    f2_path_unit #(.BYTE_W(BYTE_W)) u_f2 (
      .clk      (clk),
      .rst      (rst),
      .reg_en   (f2_reg_en[p]),
      .reg_val  (f2_reg_val[p*BYTE_W +: BYTE_W]),
      .poac_en  (poac_f2_en[p]),
      .poac_val (poac_f2_val[p*BYTE_W +: BYTE_W]),
      .fill     (oh_default),
      .slot     (f2_slot[p]),
      .f2_q     (f2_out[p*BYTE_W +: BYTE_W])
    );
  end

endmodule

// File: rtl/oh_ins_chk.sv
module oh_ins_chk #(
  parameter int NUM_PATHS = 3,
  parameter int BYTE_W    = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        enh_rdi,
  input logic [NUM_PATHS-1:0]        g1_slot,
  input logic [NUM_PATHS-1:0]        f2_slot,
  input logic [NUM_PATHS-1:0]        f2_reg_en,
  input logic [NUM_PATHS*BYTE_W-1:0] f2_reg_val,
  input logic [NUM_PATHS-1:0]        poac_f2_en,
  input logic                        oh_default,
  input logic [NUM_PATHS*BYTE_W-1:0] g1_out,
  input logic [NUM_PATHS*BYTE_W-1:0] f2_out
);

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_chk
    AST_G1_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
      g1_slot[p] |=> (g1_out[p*BYTE_W] == 1'b0));  // R1

    AST_REI_CAPPED: assert property (@(posedge clk) disable iff (rst)
      g1_slot[p] |=> (g1_out[p*BYTE_W+4 +: 4] <= 4'd8));  // R2

    AST_RDI_PLAIN_CODES: assert property (@(posedge clk) disable iff (rst)
      (g1_slot[p] && !enh_rdi) |=> (g1_out[p*BYTE_W+1 +: 2] == 2'b00));  // R3

    AST_RDI_ENH_CODES: assert property (@(posedge clk) disable iff (rst)
      (g1_slot[p] && enh_rdi) |=>
        ((g1_out[p*BYTE_W+1 +: 3] == 3'b001) || (g1_out[p*BYTE_W+1 +: 3] == 3'b010) ||
         (g1_out[p*BYTE_W+1 +: 3] == 3'b101) || (g1_out[p*BYTE_W+1 +: 3] == 3'b110)));  // R4

    AST_F2_REG_FIRST: assert property (@(posedge clk) disable iff (rst)
      (f2_slot[p] && f2_reg_en[p]) |=>
        (f2_out[p*BYTE_W +: BYTE_W] == $past(f2_reg_val[p*BYTE_W +: BYTE_W])));  // R9

    AST_F2_FILL: assert property (@(posedge clk) disable iff (rst)
      (f2_slot[p] && !f2_reg_en[p] && !poac_f2_en[p]) |=>
        (f2_out[p*BYTE_W +: BYTE_W] == {BYTE_W{$past(oh_default)}}));  // R9

    AST_G1_HOLD: assert property (@(posedge clk) disable iff (rst)
      !g1_slot[p] |=> $stable(g1_out[p*BYTE_W +: BYTE_W]));  // R10

    AST_F2_HOLD: assert property (@(posedge clk) disable iff (rst)
      !f2_slot[p] |=> $stable(f2_out[p*BYTE_W +: BYTE_W]));  // R10
  end

endmodule

bind path_oh_inserter oh_ins_chk #(.NUM_PATHS(NUM_PATHS), .BYTE_W(BYTE_W)) u_oh_ins_chk (
  .clk        (clk),
  .rst        (rst),
  .enh_rdi    (enh_rdi),
  .g1_slot    (g1_slot),
  .f2_slot    (f2_slot),
  .f2_reg_en  (f2_reg_en),
  .f2_reg_val (f2_reg_val),
  .poac_f2_en (poac_f2_en),
  .oh_default (oh_default),
  .g1_out     (g1_out),
  .f2_out     (f2_out)
);

// File: tb/tb_path_oh_inserter.sv
module tb_path_oh_inserter;

  localparam int NP = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          stm1_mode, enh_rdi, prot_sel, err_inject, oh_default;
  logic [NP*4-1:0] loc_err_cnt, prot_err_cnt;
  logic [NP*5-1:0] loc_defects, prot_defects;
  logic [NP-1:0] rei_inh, f2_reg_en, poac_f2_en, g1_slot, f2_slot;
  logic [NP*8-1:0] f2_reg_val, poac_f2_val, g1_out, f2_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  path_oh_inserter #(.NUM_PATHS(NP)) dut (
    .clk(clk), .rst(rst), .stm1_mode(stm1_mode), .enh_rdi(enh_rdi), .prot_sel(prot_sel),
    .loc_err_cnt(loc_err_cnt), .loc_defects(loc_defects),
    .prot_err_cnt(prot_err_cnt), .prot_defects(prot_defects),
    .rei_inh(rei_inh), .err_inject(err_inject),
    .f2_reg_en(f2_reg_en), .f2_reg_val(f2_reg_val),
    .poac_f2_en(poac_f2_en), .poac_f2_val(poac_f2_val), .oh_default(oh_default),
    .g1_slot(g1_slot), .f2_slot(f2_slot), .g1_out(g1_out), .f2_out(f2_out)
  );

  // defect bits: 0 ais, 1 lop, 2 tim, 3 uneq, 4 plm
  localparam logic [4:0] D_AIS = 5'b00001, D_LOP = 5'b00010, D_TIM = 5'b00100,
                         D_UNEQ = 5'b01000, D_PLM = 5'b10000;

  function automatic logic [7:0] g1v(input logic [3:0] rei, input logic [2:0] rdi);
    return {rei, rdi, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic g1_strobe(input logic [NP-1:0] m);
    @(negedge clk); g1_slot = m;
    @(negedge clk); g1_slot = '0;
  endtask

  task automatic f2_strobe(input logic [NP-1:0] m);
    @(negedge clk); f2_slot = m;
    @(negedge clk); f2_slot = '0;
  endtask

  task automatic clear_inputs;
    stm1_mode = 0; enh_rdi = 0; prot_sel = 0; err_inject = 0; oh_default = 0;
    loc_err_cnt = '0; prot_err_cnt = '0; loc_defects = '0; prot_defects = '0;
    rei_inh = '0; f2_reg_en = '0; poac_f2_en = '0; f2_reg_val = '0; poac_f2_val = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10 reset g1", g1_out[7:0], 8'h00);
    chk("R10 reset g1 p2", g1_out[23:16], 8'h00);
    chk("R10 reset f2", f2_out[15:8], 8'h00);
  endtask

  task automatic t_rei_count;
    clear_inputs();
    loc_err_cnt[3:0] = 4'd5; loc_err_cnt[7:4] = 4'd12; loc_err_cnt[11:8] = 4'd8;
    g1_strobe(3'b111);
    chk("R2 count 5", g1_out[7:0], g1v(4'd5, 3'b000));
    chk("R2 count 12 capped", g1_out[15:8], g1v(4'd8, 3'b000));
    chk("R1 R2 count 8", g1_out[23:16], g1v(4'd8, 3'b000));
  endtask

  task automatic t_rdi_plain;
    clear_inputs();
    loc_defects[4:0] = D_AIS; loc_defects[9:5] = D_TIM | D_UNEQ | D_PLM; loc_defects[14:10] = D_LOP;
    g1_strobe(3'b111);
    chk("R3 ais", g1_out[7:0], g1v(4'd0, 3'b100));
    chk("R3 tim/uneq/plm ignored", g1_out[15:8], g1v(4'd0, 3'b000));
    chk("R3 lop", g1_out[23:16], g1v(4'd0, 3'b100));
  endtask

  task automatic t_rdi_enh;
    clear_inputs(); enh_rdi = 1;
    loc_defects[4:0] = '0; loc_defects[9:5] = D_PLM; loc_defects[14:10] = D_TIM;
    g1_strobe(3'b111);
    chk("R4 none", g1_out[7:0], g1v(4'd0, 3'b001));
    chk("R4 plm", g1_out[15:8], g1v(4'd0, 3'b010));
    chk("R4 tim", g1_out[23:16], g1v(4'd0, 3'b110));
    loc_defects[4:0] = D_AIS | D_TIM | D_PLM; loc_defects[9:5] = D_UNEQ | D_PLM;
    loc_defects[14:10] = D_LOP | D_UNEQ;
    loc_err_cnt[3:0] = 4'd3;
    g1_strobe(3'b111);
    chk("R4 ais over tim/plm", g1_out[7:0], g1v(4'd3, 3'b101));
    chk("R4 uneq over plm", g1_out[15:8], g1v(4'd0, 3'b110));
    chk("R4 lop over uneq", g1_out[23:16], g1v(4'd0, 3'b101));
  endtask

  task automatic t_prot_sel;
    clear_inputs();
    loc_err_cnt[3:0] = 4'd2; prot_err_cnt[3:0] = 4'd7; prot_defects[4:0] = D_LOP;
    prot_sel = 1;
    g1_strobe(3'b001);
    chk("R5 protection source", g1_out[7:0], g1v(4'd7, 3'b100));
    prot_sel = 0;
    g1_strobe(3'b001);
    chk("R5 local source", g1_out[7:0], g1v(4'd2, 3'b000));
  endtask

  task automatic t_inhibit_inject;
    clear_inputs();
    rei_inh = 3'b010; loc_err_cnt[7:4] = 4'd6; loc_err_cnt[3:0] = 4'd4;
    g1_strobe(3'b011);
    chk("R6 inhibited no pulse", g1_out[15:8], 8'h00);
    chk("R6 uninhibited path keeps count", g1_out[7:0], g1v(4'd4, 3'b000));
    @(negedge clk); err_inject = 1;
    @(negedge clk); err_inject = 0;
    @(negedge clk); err_inject = 1;
    @(negedge clk); err_inject = 0;
    repeat (2) @(negedge clk);
    chk("R10 hold before slot", g1_out[15:8], 8'h00);
    g1_strobe(3'b011);
    chk("R7 queued pulses give one error", g1_out[15:8], g1v(4'd1, 3'b000));
    chk("R6 pulse does not touch open path", g1_out[7:0], g1v(4'd4, 3'b000));
    g1_strobe(3'b010);
    chk("R7 used once", g1_out[15:8], 8'h00);
    // collision: pulse and slot in the same cycle
    @(negedge clk); err_inject = 1; g1_slot = 3'b010;
    @(negedge clk); err_inject = 0; g1_slot = '0;
    chk("R7 same-cycle pulse", g1_out[15:8], g1v(4'd1, 3'b000));
    g1_strobe(3'b010);
    chk("R7 nothing left pending", g1_out[15:8], 8'h00);
  endtask

  task automatic t_stm1;
    clear_inputs(); stm1_mode = 1;
    loc_err_cnt[3:0] = 4'd4; loc_err_cnt[7:4] = 4'd3;
    rei_inh = 3'b001;
    g1_strobe(3'b011);
    chk("R8 path0 inhibit", g1_out[7:0], 8'h00);
    chk("R8 path1 follows path0 inhibit", g1_out[15:8], 8'h00);
    rei_inh = 3'b010;
    g1_strobe(3'b011);
    chk("R8 own inhibit ignored", g1_out[15:8], g1v(4'd3, 3'b000));
    chk("R8 path0 open", g1_out[7:0], g1v(4'd4, 3'b000));
  endtask

  task automatic t_f2;
    clear_inputs();
    f2_reg_val = 24'hC3_5A_A5; poac_f2_val = 24'h11_22_33;
    f2_reg_en = 3'b001; poac_f2_en = 3'b011;
    f2_strobe(3'b111);
    chk("R9 register wins", f2_out[7:0], 8'hA5);
    chk("R9 poac", f2_out[15:8], 8'h22);
    chk("R9 fill zeros", f2_out[23:16], 8'h00);
    oh_default = 1;
    f2_strobe(3'b100);
    chk("R9 fill ones", f2_out[23:16], 8'hFF);
    f2_reg_en = 3'b111;
    g1_strobe(3'b111);
    chk("R10 f2 unchanged by g1 slot", f2_out[23:16], 8'hFF);
    f2_strobe(3'b100);
    chk("R9 register after fill", f2_out[23:16], 8'hC3);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clear_inputs();
    g1_slot = '0; f2_slot = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_rei_count();
    t_rdi_plain();
    t_rdi_enh();
    t_prot_sel();
    t_inhibit_inject();
    t_stm1();
    t_f2();
    finish_run();
  end

endmodule